// File: doc/BRIEF.md
# Two-Wire Wiper Controller with One-Time Fuse Arrays

This block is the serial-bus write path of a 256-position digital potentiometer. It listens on an I2C bus and acknowledges its own 7-bit address. The upper five address bits are a parameter and the lower two come from strap pins. A write frame carries an instruction byte and then a data byte. Together they update a volatile wiper register, enter or leave shutdown, open a temporary overwrite window, or burn the data value into one of two one-time fuse arrays. A read frame returns the effective wiper code.

SCL and SDA are sampled by the system clock through two-flop synchronisers. START and STOP are recognised from the synchronised lines. The slave pulls SDA low only while SCL is low. The fuse arrays are modelled as sticky registers that only the power-on reset clears. The ordinary reset reloads the wiper from the newest valid fuse, or from midscale when no fuse is burned. Instruction flags (shutdown, overwrite) take effect when the instruction byte is acknowledged. The data byte takes effect when its eighth bit has been received.

Top module: `otp_wiper_i2c`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {ADDR_HI, addr_pins}. Any other address gets no acknowledge and changes nothing.
- R2: In a write frame to this slave, SDA is pulled low during the ninth SCL pulse of the address, instruction and data bytes. sda_oe changes only while SCL is low.
- R3: After power-on reset the wiper code is 0x80. With no fuse burned, a write with instruction 0x00 makes the data byte the wiper code.
- R4: Instruction bit 6 set to 1 makes shutdown 1 and the wiper code 0. The register keeps its value, and data written during shutdown appears once a frame with bit 6 at 0 releases it. A frame may end after the instruction byte.
- R5: A frame whose instruction bit 4 is 1 is acknowledged in full but changes no output or state.
- R6: Instruction bit 5 set to 1 burns the data byte into a fuse array: array 1 when bit 7 is 0, array 2 when bit 7 is 1. A valid burn gives burn_pulse for exactly one clock and makes the data the wiper code.
- R7: Burning array 2 while array 1 is unburned disables array 1. A later burn request to array 1 is then refused.
- R8: A burn request to a used or disabled array leaves the fuses and the wiper unchanged and gives no strobe. It sets burn_err, which holds until reset.
- R9: Once any fuse is burned, a write with bits 5 and 3 both at 0 leaves the wiper code unchanged.
- R10: Instruction bit 3 set to 1 lets the data byte set the wiper code even after a burn. A later frame with bit 3 at 0 restores the code held before the overwrite.
- R11: The ordinary reset clears shutdown, overwrite and burn_err. It loads the wiper with array 2's value if array 2 is burned, else array 1's value if array 1 is burned, else 0x80. Fuses survive it.
- R12: A read frame (R/W bit 1) is acknowledged, and the slave then sends the current wiper code MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| por_n | input | 1 | Synchronous active-low power-on reset, clears the fuse model |
| addr_pins | input | 2 | Strap pins giving the two low address bits |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wiper_code | output | 8 | Effective wiper code |
| shutdown | output | 1 | Shutdown active |
| burn_pulse | output | 1 | One-clock strobe for a valid fuse burn |
| burn_err | output | 1 | Sticky flag for a refused burn request |

## Verification
Two functions can land on the same clock edge. One pair is the fuse burn and the shutdown entry, carried in one instruction byte with bits 6 and 5 both set. The other is the array 2 burn that also disables array 1. The bench sends instruction 0x60 and checks four things: the strobe count rises by one, shutdown is 1, the code stays 0, and after a release frame the burned value appears. A later array-1 request must then raise burn_err with no strobe. All expected values come from a bench model written from the requirements, and a sweep of all 128 addresses checks the acknowledge pattern.

// File: rtl/otp_wiper_i2c.sv
module otp_wiper_i2c #(
  parameter logic [4:0] ADDR_HI  = 5'b01011,
  parameter logic [7:0] MIDSCALE = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic [1:0] addr_pins,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] wiper_code,
  output logic       shutdown,
  output logic       burn_pulse,
  output logic       burn_err
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_INS, P_DATA, P_READ, P_SKIP} phase_t;

  phase_t     phase;
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       ins_ok, ins_sel2, ins_burn, ins_ow;
  logic [7:0] wreg, owv;
  logic       ow, sd;
  logic       f1_used, f1_dis, f2_used;
  logic [7:0] f1_val, f2_val;
  logic       data_done, wr_burn, ok1, ok2, go1, go2, bad, burned;
  logic [6:0] my_addr;
  logic [7:0] fuse_val, eff;

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign my_addr  = {ADDR_HI, addr_pins};

  assign burned    = f1_used | f2_used;
  assign fuse_val  = f2_used ? f2_val : (f1_used ? f1_val : MIDSCALE);
  assign data_done = (phase == P_DATA) && scl_fall && (cnt == 4'd8) && ins_ok
                     && !start_c && !stop_c;
  assign wr_burn   = data_done & ins_burn;
  assign ok1       = ~f1_used & ~f1_dis;
  assign ok2       = ~f2_used;
  assign go1       = wr_burn & ~ins_sel2 & ok1;
  assign go2       = wr_burn & ins_sel2 & ok2;
  assign bad       = wr_burn & ~(ins_sel2 ? ok2 : ok1);

  assign eff        = sd ? 8'h00 : (ow ? owv : wreg);
  assign wiper_code = eff;
  assign shutdown   = sd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      f1_used <= 1'b0; f1_dis <= 1'b0; f2_used <= 1'b0;
      f1_val  <= 8'h00; f2_val <= 8'h00;
    end else begin
      if (go1) begin
        f1_used <= 1'b1; f1_val <= sh;
      end
      if (go2) begin
        f2_used <= 1'b1; f2_val <= sh;
        if (!f1_used) f1_dis <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE; cnt <= 4'd0; sh <= 8'h00; tx <= 8'h00; sda_oe <= 1'b0;
      ins_ok <= 1'b0; ins_sel2 <= 1'b0; ins_burn <= 1'b0; ins_ow <= 1'b0;
      wreg <= fuse_val; owv <= 8'h00; ow <= 1'b0; sd <= 1'b0;
      burn_err <= 1'b0; burn_pulse <= 1'b0;
    end else begin
      burn_pulse <= go1 | go2;
      if (bad) burn_err <= 1'b1;
      if (data_done) begin
        if (go1 | go2)      wreg <= sh;
        else if (ins_burn)  wreg <= wreg;
        else if (ins_ow)    owv  <= sh;
        else if (!burned)   wreg <= sh;
      end

      if (start_c) begin
        phase <= P_ADDR; cnt <= 4'd0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase <= P_IDLE; sda_oe <= 1'b0;
      end else if (phase == P_READ) begin
        if (scl_rise) cnt <= cnt + 4'd1;
        else if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0; phase <= P_SKIP;
          end else begin
            sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
          end
        end
      end else if (phase == P_ADDR || phase == P_INS || phase == P_DATA) begin
        if (scl_rise && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && cnt == 4'd8) begin
          cnt <= 4'd9;
          case (phase)
            P_ADDR: if (sh[7:1] == my_addr) sda_oe <= 1'b1; else phase <= P_SKIP;
            P_INS: begin
              sda_oe   <= 1'b1;
              ins_ok   <= ~sh[4];
              ins_sel2 <= sh[7];
              ins_burn <= sh[5];
              ins_ow   <= sh[3];
              if (!sh[4]) begin
                sd <= sh[6];
                ow <= sh[3];
                if (sh[3] && !ow) owv <= wreg;
              end
            end
            default: sda_oe <= 1'b1;
          endcase
        end else if (scl_fall && cnt == 4'd9) begin
          sda_oe <= 1'b0;
          cnt    <= 4'd0;
          case (phase)
            P_ADDR: if (sh[0]) begin
                      phase <= P_READ; tx <= eff; sda_oe <= ~eff[7];
                    end else phase <= P_INS;
            P_INS:  phase <= P_DATA;
            default: phase <= P_SKIP;
          endcase
        end
      end
    end
  end

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burn_pulse |=> !burn_pulse);

  assert_sda_lowphase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_err_nopulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burn_err) |-> !burn_pulse);

  assert_fuse_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    (f1_used || f2_used) |=> (f1_used || f2_used));

  assert_dis_exclusive_R7: assert property (@(posedge clk) disable iff (!por_n)
    !(f1_used && f1_dis));

endmodule

// File: tb/otp_wiper_i2c_tb_top.sv
`timescale 1ns/1ps
module otp_wiper_i2c_tb_top;
  localparam logic [4:0] AHI = 5'b01011;
  localparam int Q = 5;

  logic clk = 0, rst_n = 0, por_n = 0;
  logic [1:0] pins = 2'b10;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, shutdown, burn_pulse, burn_err;
  logic [7:0] wiper_code;
  logic sda_line;
  int checks = 0, failures = 0, pulses = 0, cyc = 0;
  bit done = 0;

  bit m_f1u, m_f1d, m_f2u, m_ow, m_sd, m_err;
  logic [7:0] m_f1v, m_f2v, m_w, m_owv;
  int m_pulses = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #2.5 clk = ~clk;

  otp_wiper_i2c #(.ADDR_HI(AHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr_pins(pins),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wiper_code(wiper_code), .shutdown(shutdown),
    .burn_pulse(burn_pulse), .burn_err(burn_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (burn_pulse) pulses <= pulses + 1;
    if (cyc == 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic [7:0] exp_code();
    return m_sd ? 8'h00 : (m_ow ? m_owv : m_w);
  endfunction

  task automatic check_outs(input string tag);
    chk(wiper_code == exp_code(), tag, wiper_code, exp_code());
    chk(shutdown == m_sd, tag, shutdown, m_sd);
    chk(burn_err == m_err, tag, burn_err, m_err);
    chk(pulses == m_pulses, tag, pulses, m_pulses);
  endtask

  task automatic i2c_start();
    sda_m = 1; w(Q); scl_m = 1; w(Q); sda_m = 0; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; w(Q); scl_m = 1; w(Q); sda_m = 1; w(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q);
    end
    sda_m = 1; w(Q); scl_m = 1; w(Q); ack = !sda_line; w(Q); scl_m = 0; w(Q);
  endtask

  task automatic recv(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1; w(Q); b[i] = sda_line; w(Q); scl_m = 0; w(Q);
    end
    sda_m = 1; w(Q); scl_m = 1; w(2*Q); scl_m = 0; w(Q);
  endtask

  task automatic frame(input logic [7:0] ins, input logic [7:0] d, input bit with_data);
    bit a0, a1, a2;
    i2c_start();
    send({AHI, pins, 1'b0}, a0);
    send(ins, a1);
    a2 = 1;
    if (with_data) send(d, a2);
    i2c_stop();
    chk(a0 && a1 && a2, "R2 ack", {a0, a1, a2}, 3'b111);
    if (!ins[4]) begin
      m_sd = ins[6];
      if (ins[3] && !m_ow) m_owv = m_w;
      m_ow = ins[3];
      if (with_data) begin
        if (ins[5]) begin
          if (ins[7] ? !m_f2u : (!m_f1u && !m_f1d)) begin
            m_pulses++;
            if (ins[7]) begin
              m_f2u = 1; m_f2v = d;
              if (!m_f1u) m_f1d = 1;
            end else begin
              m_f1u = 1; m_f1v = d;
            end
            m_w = d;
          end else m_err = 1;
        end else if (ins[3]) m_owv = d;
        else if (!(m_f1u || m_f2u)) m_w = d;
      end
    end
  endtask

  task automatic readback(input string tag);
    bit a; logic [7:0] b;
    i2c_start();
    send({AHI, pins, 1'b1}, a);
    recv(b);
    i2c_stop();
    chk(a, tag, a, 1);
    chk(b == exp_code(), tag, b, exp_code());
  endtask

  task automatic do_reset(input bit por);
    w(2); rst_n = 0; if (por) por_n = 0; w(4); rst_n = 1; por_n = 1; w(4);
    if (por) begin m_f1u = 0; m_f1d = 0; m_f2u = 0; end
    m_w = m_f2u ? m_f2v : (m_f1u ? m_f1v : 8'h80);
    m_ow = 0; m_sd = 0; m_err = 0;
  endtask

  initial begin
    bit a;
    do_reset(1);
    check_outs("R3 reset");
    chk(wiper_code == 8'h80, "R11 midscale", wiper_code, 8'h80);

    for (int ad = 0; ad < 128; ad++) begin
      i2c_start();
      send({ad[6:0], 1'b0}, a);
      i2c_stop();
      chk(a == (ad[6:0] == {AHI, pins}), "R1 sweep", a, ad[6:0] == {AHI, pins});
    end
    check_outs("R1 no effect");
    pins = 2'b01;
    i2c_start(); send({AHI, 2'b10, 1'b0}, a); i2c_stop();
    chk(!a, "R1 old pins", a, 0);
    i2c_start(); send({AHI, 2'b01, 1'b0}, a); i2c_stop();
    chk(a, "R1 new pins", a, 1);

    for (int k = 0; k < 16; k++) begin
      frame(8'h00, 8'(k * 17 + 3), 1);
      check_outs("R3 write");
      readback("R12 read");
    end

    frame(8'h10, 8'h33, 1);
    check_outs("R5 reserved");
    frame(8'h58, 8'h44, 1);
    check_outs("R5 reserved flags");

    frame(8'h40, 8'h5A, 1);
    check_outs("R4 enter");
    readback("R12 shutdown read");
    frame(8'h40, 8'h66, 1);
    check_outs("R4 write in shutdown");
    frame(8'h00, 8'h00, 0);
    check_outs("R4 release");
    chk(wiper_code == 8'h66, "R4 release value", wiper_code, 8'h66);

    frame(8'h60, 8'h4C, 1);
    check_outs("R6 burn with shutdown");
    chk(shutdown && wiper_code == 0, "R4 burn in shutdown", wiper_code, 0);
    frame(8'h00, 8'h00, 0);
    check_outs("R6 burn1 visible");
    chk(wiper_code == 8'h4C, "R6 burn1 value", wiper_code, 8'h4C);

    frame(8'h00, 8'h11, 1);
    check_outs("R9 ignored write");
    frame(8'h08, 8'h99, 1);
    check_outs("R10 overwrite");
    chk(wiper_code == 8'h99, "R10 overwrite value", wiper_code, 8'h99);
    frame(8'h00, 8'h00, 0);
    check_outs("R10 revert");
    chk(wiper_code == 8'h4C, "R10 revert value", wiper_code, 8'h4C);

    frame(8'h20, 8'h22, 1);
    check_outs("R8 reburn refused");
    chk(burn_err, "R8 err flag", burn_err, 1);
    frame(8'h00, 8'h00, 0);
    chk(burn_err, "R8 err sticky", burn_err, 1);

    do_reset(0);
    check_outs("R11 reload array1");
    frame(8'hA0, 8'hC3, 1);
    check_outs("R6 burn2");
    do_reset(0);
    check_outs("R11 reload array2");
    chk(wiper_code == 8'hC3, "R11 array2 value", wiper_code, 8'hC3);

    do_reset(1);
    check_outs("R11 por clears fuses");
    frame(8'hA8, 8'h37, 1);
    check_outs("R7 burn2 first");
    frame(8'h20, 8'h01, 1);
    check_outs("R7 array1 disabled");
    chk(burn_err, "R7 err", burn_err, 1);
    do_reset(0);
    check_outs("R11 reload after lockout");
    chk(wiper_code == 8'h37, "R7 value kept", wiper_code, 8'h37);
    readback("R12 final read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule